// File: doc/BRIEF.md
# Card PHY power-up sequencer

This block walks a memory-card PHY through its power transitions in hardware, so that the host controller only has to raise a request and wait for a completion pulse. A power-off request pulls the PHY's power-down control (active low) and its DLL enable low, and then completes at once. A power-on request does the same and then runs the full bring-up. It waits for the calibration pads to settle and releases power-down. It checks calibration once after a fixed delay. It programs the DLL frequency band, enables the DLL, and polls DLL lock at a fixed interval until lock is seen or a long window runs out.

The card clock rate arrives as a number of hertz and is latched when a power-on request is accepted. From it the block picks one of four frequency bands. It also raises a warning when the rate is too far from the nominal value of its band, or above the top band. A rate of zero means no card clock is running yet. In that case the DLL is still enabled, but the block does not wait for lock, because lock cannot happen without a clock. All delays are counted in cycles of the reference clock, and its frequency is a parameter.

Top module: `card_phy_seq`

## Requirements
- R1: After reset, pwrdn_n_o, dll_en_o, freq_sel_o, busy_o, done_o, err_o and rate_warn_o are all 0.
- R2: A request accepted while idle drives pwrdn_n_o and dll_en_o low on the clock edge that samples it. A power-off request also completes on that same edge, with done_o pulsing, err_o set to 0, rate_warn_o cleared and busy_o staying low. If both requests are high together, power-off wins.
- R3: The frequency band is taken from rate_hz_i as latched at the power-on request. From 1 to 74,999,999 Hz the code is 1. From 75,000,000 to 124,999,999 Hz the code is 2. From 125,000,000 to 174,999,999 Hz the code is 3. At 0 Hz, and at 175,000,000 Hz or more, the code is 0. The code appears on freq_sel_o only after calibration has passed.
- R4: rate_warn_o is updated on each accepted power-on request. It is 1 when the rate is above 200,000,000 Hz, or when the rate is above 50,000,000 Hz and differs from its band's nominal value (50, 100, 150 or 200 MHz) by more than 15,000,000 Hz. A rate of 0 never warns. The warning does not alter the sequence.
- R5: pwrdn_n_o rises exactly 3*CYC_US reference cycles after the power-on request edge, where CYC_US is the number of reference cycles per microsecond.
- R6: cal_done_i is sampled once, 5*CYC_US cycles after pwrdn_n_o rises. If it is 0, the sequence ends with err_o = 1, dll_en_o stays 0 and freq_sel_o keeps its previous value.
- R7: When calibration passes, freq_sel_o takes the new band on the sampling edge, and dll_en_o rises one cycle later.
- R8: With a latched rate of 0, the sequence ends with err_o = 0 on the same edge that raises dll_en_o.
- R9: Otherwise dll_rdy_i is sampled every CYC_US cycles, with the first sample CYC_US cycles after dll_en_o rises, for at most LOCK_US samples. The first sample that reads 1 ends the sequence with err_o = 0.
- R10: If none of the LOCK_US samples reads 1, the sequence ends with err_o = 2, and pwrdn_n_o and dll_en_o both stay high.
- R11: Power-on and power-off requests that arrive while busy_o is high have no effect on any output.
- R12: busy_o is high from the accepting edge of a power-on request until the completion edge. done_o is a one-cycle pulse on completion. err_o (0 success, 1 calibration timeout, 2 DLL timeout) holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Power-on request, sampled while idle |
| pwr_off_i | input | 1 | Power-off request, sampled while idle |
| rate_hz_i | input | RATE_W | Card clock rate in Hz |
| cal_done_i | input | 1 | PHY calibration complete status |
| dll_rdy_i | input | 1 | PHY DLL lock status |
| pwrdn_n_o | output | 1 | PHY power-down control, active low |
| dll_en_o | output | 1 | PHY DLL enable |
| freq_sel_o | output | 2 | DLL frequency band code |
| busy_o | output | 1 | Power-on sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result code of the last sequence |
| rate_warn_o | output | 1 | Rate outside the supported range |

## Verification
The bench aims at the edges of the rate bands and of the warning band: 65,000,000 against 65,000,001 Hz, 74,999,999 against 75,000,000 Hz, 200 MHz against 215 MHz, and 1 Hz. An off-by-one comparator at any of these points would show up as a wrong band code or a wrong warning level. It runs a calibration failure, where a faulty design would still enable the DLL or overwrite the band. It runs a zero-rate start, where a faulty design would sit in the poll loop, and a DLL that never locks, where a faulty design would end early or drop the PHY controls. It also aims at the exact cycles of power-up, of the calibration sample and of each lock poll, since a timer loaded one count off would move every later event. Stray requests in the middle of a sequence and simultaneous on and off requests check that the sequence cannot be restarted or cut short.

// File: rtl/card_phy_seq_pkg.sv
package card_phy_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CAL,
    ST_DLLON,
    ST_POLL
  } seq_state_e;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_CAL  = 2'd1;
  localparam logic [1:0] ERR_DLL  = 2'd2;

  localparam logic [1:0] BAND_200 = 2'd0;
  localparam logic [1:0] BAND_50  = 2'd1;
  localparam logic [1:0] BAND_100 = 2'd2;
  localparam logic [1:0] BAND_150 = 2'd3;
endpackage

// File: rtl/card_phy_rate_class.sv
module card_phy_rate_class #(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [1:0]        band_o,
  output logic              warn_o,
  output logic              zero_o
);
  import card_phy_seq_pkg::*;

  logic [RATE_W-1:0] nominal;
  logic [RATE_W-1:0] diff;

  always_comb begin
    if (rate_i == '0) begin
      band_o  = BAND_200;
      nominal = RATE_W'(200_000_000);
    end else if (rate_i < RATE_W'(75_000_000)) begin
      band_o  = BAND_50;
      nominal = RATE_W'(50_000_000);
    end else if (rate_i < RATE_W'(125_000_000)) begin
      band_o  = BAND_100;
      nominal = RATE_W'(100_000_000);
    end else if (rate_i < RATE_W'(175_000_000)) begin
      band_o  = BAND_150;
      nominal = RATE_W'(150_000_000);
    end else begin
      band_o  = BAND_200;
      nominal = RATE_W'(200_000_000);
    end
    diff   = (rate_i > nominal) ? rate_i - nominal : nominal - rate_i;
    zero_o = (rate_i == '0);
    warn_o = !zero_o &&
             ((rate_i > RATE_W'(50_000_000) && diff > RATE_W'(15_000_000)) ||
              (rate_i > RATE_W'(200_000_000)));
  end
endmodule

// File: rtl/card_phy_timer.sv
module card_phy_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/card_phy_seq_fsm.sv
module card_phy_seq_fsm #(
  parameter int CYC_US  = 50,
  parameter int LOCK_US = 50000,
  parameter int TMR_W   = 9,
  parameter int POLL_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic [1:0]       band_i,
  input  logic             warn_i,
  input  logic             zero_i,
  input  logic             cal_done_i,
  input  logic             dll_rdy_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             pwrdn_n_o,
  output logic             dll_en_o,
  output logic [1:0]       freq_sel_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic             warn_o
);
  import card_phy_seq_pkg::*;

  localparam logic [TMR_W-1:0] LD_PRE  = TMR_W'(3 * CYC_US - 1);
  localparam logic [TMR_W-1:0] LD_CAL  = TMR_W'(5 * CYC_US - 1);
  localparam logic [TMR_W-1:0] LD_POLL = TMR_W'(CYC_US - 1);
  localparam logic [POLL_W-1:0] LD_TRIES = POLL_W'(LOCK_US - 1);

  seq_state_e        state_q;
  logic [1:0]        band_q;
  logic              zero_q;
  logic [POLL_W-1:0] tries_q;

  wire start_on = (state_q == ST_IDLE) && on_req_i && !off_req_i;
  wire poll_hit = (state_q == ST_POLL) && tmr_expired_i;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = LD_POLL;
    if (start_on) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = LD_PRE;
    end else if (state_q == ST_PRE && tmr_expired_i) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = LD_CAL;
    end else if (state_q == ST_DLLON && !zero_q) begin
      tmr_load_o = 1'b1;
    end else if (poll_hit && !dll_rdy_i && tries_q != '0) begin
      tmr_load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      band_q     <= BAND_200;
      zero_q     <= 1'b0;
      tries_q    <= '0;
      pwrdn_n_o  <= 1'b0;
      dll_en_o   <= 1'b0;
      freq_sel_o <= BAND_200;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= ERR_NONE;
      warn_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (off_req_i) begin
            pwrdn_n_o <= 1'b0;
            dll_en_o  <= 1'b0;
            err_o     <= ERR_NONE;
            warn_o    <= 1'b0;
            done_o    <= 1'b1;
          end else if (on_req_i) begin
            pwrdn_n_o <= 1'b0;
            dll_en_o  <= 1'b0;
            err_o     <= ERR_NONE;
            warn_o    <= warn_i;
            band_q    <= band_i;
            zero_q    <= zero_i;
            busy_o    <= 1'b1;
            state_q   <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (tmr_expired_i) begin
            pwrdn_n_o <= 1'b1;
            state_q   <= ST_CAL;
          end
        end
        ST_CAL: begin
          if (tmr_expired_i) begin
            if (cal_done_i) begin
              freq_sel_o <= band_q;
              state_q    <= ST_DLLON;
            end else begin
              err_o   <= ERR_CAL;
              done_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DLLON: begin
          dll_en_o <= 1'b1;
          if (zero_q) begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tries_q <= LD_TRIES;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tmr_expired_i) begin
            if (dll_rdy_i) begin
              done_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_IDLE;
            end else if (tries_q == '0) begin
              err_o   <= ERR_DLL;
              done_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              tries_q <= tries_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/card_phy_seq.sv
module card_phy_seq #(
  parameter int REF_HZ  = 50_000_000,
  parameter int LOCK_US = 50_000,
  parameter int RATE_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              pwr_off_i,
  input  logic [RATE_W-1:0] rate_hz_i,
  input  logic              cal_done_i,
  input  logic              dll_rdy_i,
  output logic              pwrdn_n_o,
  output logic              dll_en_o,
  output logic [1:0]        freq_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic              rate_warn_o
);
  localparam int CYC_US = (REF_HZ >= 1_000_000) ? REF_HZ / 1_000_000 : 1;
  localparam int TMR_W  = $clog2(5 * CYC_US + 1);
  localparam int POLL_W = $clog2(LOCK_US + 1);

  logic [1:0]       band;
  logic             warn;
  logic             zero;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;

  card_phy_rate_class #(.RATE_W(RATE_W)) u_class (
    .rate_i (rate_hz_i),
    .band_o (band),
    .warn_o (warn),
    .zero_o (zero)
  );

  card_phy_timer #(.W(TMR_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  card_phy_seq_fsm #(
    .CYC_US  (CYC_US),
    .LOCK_US (LOCK_US),
    .TMR_W   (TMR_W),
    .POLL_W  (POLL_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .on_req_i      (pwr_on_i),
    .off_req_i     (pwr_off_i),
    .band_i        (band),
    .warn_i        (warn),
    .zero_i        (zero),
    .cal_done_i    (cal_done_i),
    .dll_rdy_i     (dll_rdy_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .pwrdn_n_o     (pwrdn_n_o),
    .dll_en_o      (dll_en_o),
    .freq_sel_o    (freq_sel_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .warn_o        (rate_warn_o)
  );
endmodule

// File: rtl/card_phy_seq_chk.sv
module card_phy_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrdn_n_o,
  input logic       dll_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] err_o
);
  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r12_err_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(err_o));

  a_r6_cal_fail_dll_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd1) |-> !dll_en_o);

  a_r10_timeout_keeps_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'd2) |-> (pwrdn_n_o && dll_en_o));

  a_r7_dll_after_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_en_o |-> pwrdn_n_o);

  a_r7_dll_rise_in_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_en_o) |-> $past(busy_o));

  a_r2_err_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o != 2'd3);
endmodule

bind card_phy_seq card_phy_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwrdn_n_o (pwrdn_n_o),
  .dll_en_o  (dll_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/card_phy_seq_tb.sv
module card_phy_seq_tb;
  localparam int REF_HZ = 10_000_000;
  localparam int LOCK_US = 200;
  localparam int CUS = REF_HZ / 1_000_000;
  localparam int T_PRE = 3 * CUS;
  localparam int T_CAL = 5 * CUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0, pwr_off = 1'b0, cal_done = 1'b0, dll_rdy = 1'b0;
  logic [31:0] rate = '0;
  logic pwrdn_n, dll_en, busy, done, warn;
  logic [1:0] freq, err;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  card_phy_seq #(.REF_HZ(REF_HZ), .LOCK_US(LOCK_US), .RATE_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .pwr_off_i(pwr_off),
    .rate_hz_i(rate), .cal_done_i(cal_done), .dll_rdy_i(dll_rdy),
    .pwrdn_n_o(pwrdn_n), .dll_en_o(dll_en), .freq_sel_o(freq), .busy_o(busy),
    .done_o(done), .err_o(err), .rate_warn_o(warn)
  );

  function automatic int band_of(longint r);
    if (r == 0) return 0;
    if (r <= 74_999_999) return 1;
    if (r <= 124_999_999) return 2;
    if (r <= 174_999_999) return 3;
    return 0;
  endfunction

  function automatic bit warn_of(longint r);
    longint nom, d;
    int b;
    if (r == 0) return 0;
    b = band_of(r);
    nom = (b == 1) ? 50_000_000 : (b == 2) ? 100_000_000 : (b == 3) ? 150_000_000 : 200_000_000;
    d = (r > nom) ? r - nom : nom - r;
    return (r > 50_000_000 && d > 15_000_000) || (r > 200_000_000);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, elapsed-time based
  bit m_pdb, m_en, m_busy, m_done, m_warn, m_zero;
  int m_freq, m_err, m_band, el;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pdb = 0; m_en = 0; m_busy = 0; m_done = 0; m_warn = 0; m_zero = 0;
      m_freq = 0; m_err = 0; m_band = 0; el = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (pwr_off) begin
          m_pdb = 0; m_en = 0; m_err = 0; m_warn = 0; m_done = 1;
        end else if (pwr_on) begin
          m_pdb = 0; m_en = 0; m_err = 0; m_busy = 1; el = 0;
          m_warn = warn_of(rate); m_band = band_of(rate); m_zero = (rate == 0);
        end
      end else begin
        el++;
        if (el == T_PRE) m_pdb = 1;
        else if (el == T_PRE + T_CAL) begin
          if (cal_done) m_freq = m_band;
          else begin m_err = 1; m_done = 1; m_busy = 0; end
        end else if (el == T_PRE + T_CAL + 1) begin
          m_en = 1;
          if (m_zero) begin m_done = 1; m_busy = 0; end
        end else if (el > T_PRE + T_CAL + 1 && (el - T_PRE - T_CAL - 1) % CUS == 0) begin
          if (dll_rdy) begin m_done = 1; m_busy = 0; end
          else if ((el - T_PRE - T_CAL - 1) / CUS == LOCK_US) begin
            m_err = 2; m_done = 1; m_busy = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pwrdn_n == m_pdb, "R5 pwrdn_n per-cycle", pwrdn_n, m_pdb);
      chk(dll_en == m_en, "R7 dll_en per-cycle", dll_en, m_en);
      chk(freq == 2'(m_freq), "R3 freq_sel per-cycle", freq, m_freq);
      chk(busy == m_busy, "R12 busy per-cycle", busy, m_busy);
      chk(done == m_done, "R12 done per-cycle", done, m_done);
      chk(err == 2'(m_err), "R9 err per-cycle", err, m_err);
      chk(warn == m_warn, "R4 warn per-cycle", warn, m_warn);
    end
  end

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000) begin
      fails++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 150_000);
      report();
    end
  end

  int last_freq = 0;

  task automatic do_off(input bit with_on);
    @(negedge clk);
    pwr_off = 1'b1; pwr_on = with_on;
    @(negedge clk);
    pwr_off = 1'b0; pwr_on = 1'b0;
    chk(done == 1'b1, "R2 off completes at once", done, 1);
    chk(pwrdn_n == 1'b0 && dll_en == 1'b0, "R2 off drives controls low", {pwrdn_n, dll_en}, 0);
    chk(busy == 1'b0, "R2 off leaves busy low", busy, 0);
    chk(err == 2'd0, "R2 off reports success", err, 0);
  endtask

  task automatic run_on(input longint r, input bit cal, input int lock_dly, input bit poke);
    int k, pdb_at, en_k;
    int exp_err, exp_freq;
    @(negedge clk);
    rate = 32'(r); cal_done = cal; dll_rdy = 1'b0; pwr_on = 1'b1;
    @(negedge clk);
    pwr_on = 1'b0;
    k = 1; pdb_at = -1; en_k = -1;
    while (!done) begin
      if (pwrdn_n && pdb_at < 0) pdb_at = k;
      if (dll_en && en_k < 0) en_k = k;
      if (en_k >= 0 && lock_dly >= 0 && k - en_k >= lock_dly) dll_rdy = 1'b1;
      if (poke && k == 10) pwr_off = 1'b1;
      else if (poke && k == 60) pwr_on = 1'b1;
      else begin pwr_off = 1'b0; pwr_on = 1'b0; end
      @(negedge clk);
      k++;
    end
    pwr_off = 1'b0; pwr_on = 1'b0;
    exp_err = !cal ? 1 : (r == 0) ? 0 : (lock_dly < 0) ? 2 : 0;
    exp_freq = cal ? band_of(r) : last_freq;
    last_freq = exp_freq;
    if (pdb_at >= 0) chk(pdb_at == T_PRE + 1, "R5 power-up delay", pdb_at, T_PRE + 1);
    chk(err == 2'(exp_err), exp_err == 1 ? "R6 cal result" : exp_err == 2 ? "R10 lock timeout" : "R9 result", err, exp_err);
    chk(freq == 2'(exp_freq), "R3 band code", freq, exp_freq);
    chk(warn == warn_of(r), "R4 rate warning", warn, warn_of(r));
    chk(dll_en == cal, cal ? "R7 dll enabled" : "R6 dll stays off", dll_en, cal);
    chk(pwrdn_n == 1'b1, "R10 power stays up", pwrdn_n, 1);
    if (r == 0 && cal) chk(k == T_PRE + T_CAL + 2, "R8 no lock wait at zero rate", k, T_PRE + T_CAL + 2);
    if (poke) chk(pwrdn_n == 1'b1 && err == 2'(exp_err), "R11 busy requests ignored", pwrdn_n, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 done pulse one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwrdn_n == 0 && dll_en == 0 && freq == 0 && busy == 0 && done == 0 && err == 0 && warn == 0,
        "R1 reset state", {pwrdn_n, dll_en, freq, busy, done, err, warn}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_off(1'b0);
    run_on(50_000_000, 1, 25, 0);
    run_on(100_000_000, 1, 0, 0);
    run_on(150_000_000, 1, 3, 0);
    run_on(200_000_000, 1, 0, 0);
    run_on(65_000_000, 1, 0, 0);
    run_on(65_000_001, 1, 0, 0);
    run_on(74_999_999, 1, 0, 0);
    run_on(75_000_000, 1, 0, 0);
    run_on(124_999_999, 1, 0, 0);
    run_on(174_999_999, 1, 0, 0);
    run_on(215_000_000, 1, 0, 0);
    run_on(1, 1, 0, 0);
    run_on(30_000_000, 1, 0, 0);
    run_on(100_000_000, 0, 0, 0);
    run_on(0, 1, -1, 0);
    run_on(100_000_000, 1, -1, 0);
    do_off(1'b0);
    run_on(150_000_000, 1, 57, 1);
    do_off(1'b1);
    run_on(250_000_000, 1, 1, 0);
    repeat (4) @(negedge clk);
    report();
  end
endmodule